// File: doc/BRIEF.md
# Thermal Sensor Register Target on I2C

This block is the two-wire serial target side of a temperature monitor. It samples SCL and SDA in a faster system clock domain and answers its own 7-bit device address. Behind the address sits a small register bank. A latched pointer picks the register: a read-only temperature word, a one-byte configuration register, and three two-byte threshold words (low, high, critical). The pointer stays where it was last set. A host that keeps reading the temperature therefore sends only the address byte with the read direction and then clocks out data.

The converter and the threshold comparison live outside the block. The converter supplies the temperature word. The comparison logic reports threshold crossings as one-cycle event pulses. The block keeps the alarm and critical outputs, clears the alarm on a read when interrupt mode is selected, and clears both outputs when shutdown is entered. A host may read only the first byte of a two-byte register and then leave the slave driving a 0 on SDA. This case has a defined way out: clock the slave through the rest of its byte and give a NACK.

Top module: `thermo_i2c_target`

## Requirements
- R1: After reset the pointer is 0, which selects the temperature word. A read with no pointer byte returns `temp_in`, high byte first. All register outputs reset to 0 and SDA is not driven.
- R2: The pointer keeps its last written value across transactions, so a later read with no pointer byte returns the same register.
- R3: A write is the address byte with R/W=0, then a pointer byte whose bits [2:0] select the register (0 temperature, 1 configuration, 2 low limit, 3 high limit, 4 critical limit), then data. Configuration takes one data byte. Each limit takes two bytes, high byte first, and is updated when the second byte arrives.
- R4: A write with pointer 0 is acknowledged on every byte but leaves every register unchanged.
- R5: Read data is shifted out MSB first and changes only while SCL is low. A two-byte register sends its high byte then its low byte. Further ACKed bytes restart from the high byte. A one-byte register repeats its single byte.
- R6: After the last read byte the master may return ACK or NACK. A NACK releases SDA. A stop condition always releases SDA and ends the transaction.
- R7: An address other than `DEV_ADDR` is not acknowledged, and SDA stays released for the rest of that transaction.
- R8: With configuration bit 1 set (interrupt mode), acknowledging an address with R/W=1 clears `alarm_out`. With bit 1 clear (comparator mode), a read leaves `alarm_out` unchanged.
- R9: A configuration write that takes bit 0 (shutdown) from 0 to 1 clears both `alarm_out` and `crit_out`.
- R10: Suppose a two-byte register is read as one ACKed byte and bit 7 of the second byte is 0. SDA then stays low. Nine further SCL pulses with SDA released by the master end that byte with a NACK and release SDA. A stop condition is then accepted and the next transaction works normally.
- R11: A pulse on `alarm_evt` sets `alarm_out`, and a pulse on `crit_evt` sets `crit_out`. Each output holds until cleared as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (the wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| temp_in | input | 16 | Temperature word from the converter |
| alarm_evt | input | 1 | Threshold event pulse from comparison logic |
| crit_evt | input | 1 | Critical event pulse from comparison logic |
| alarm_out | output | 1 | Alarm output |
| crit_out | output | 1 | Critical alarm output |
| cfg_out | output | 8 | Configuration register (bit 0 shutdown, bit 1 interrupt mode) |
| lim_low | output | 16 | Low threshold word |
| lim_high | output | 16 | High threshold word |
| lim_crit | output | 16 | Critical threshold word |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h48 and `SYNC_STAGES` = 2, and drives SCL with a 16-clock half period. The two-stage synchronizer plus the edge and drive registers then settle well inside each SCL phase. The master changes SDA four clocks after SCL falls, which keeps the synchronized SDA edge apart from the SCL edge, so data moves are never mistaken for start or stop. With these values a few dozen bytes reach pointer persistence, the restart of the byte order on extra ACKs, the stuck-low recovery after a truncated read and both interrupt modes, all within a short run.

// File: rtl/tsi_pkg.sv
// Shared constants, register select codes and link state type for the
// thermal register target. Assumes a 3-bit pointer field.
package tsi_pkg;
    localparam int PTR_W  = 3;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [PTR_W-1:0] SEL_TEMP = 3'd0;
    localparam logic [PTR_W-1:0] SEL_CFG  = 3'd1;
    localparam logic [PTR_W-1:0] SEL_LOW  = 3'd2;
    localparam logic [PTR_W-1:0] SEL_HIGH = 3'd3;
    localparam logic [PTR_W-1:0] SEL_CRIT = 3'd4;

    localparam int CFG_SHDN = 0;
    localparam int CFG_INTM = 1;

    typedef enum logic [3:0] {
        L_IDLE, L_ADDR, L_ADDR_ACK, L_PTR, L_PTR_ACK,
        L_WDAT, L_WDAT_ACK, L_RDAT, L_RACK
    } link_st_t;

    // True for registers that carry two bytes on the bus.
    function automatic logic sel_wide(input logic [PTR_W-1:0] s);
        return (s == SEL_TEMP) || (s == SEL_LOW) || (s == SEL_HIGH) || (s == SEL_CRIT);
    endfunction
endpackage

// File: rtl/tsi_sync.sv
// Multi-flop synchronizer for one bus line. Resets to 1 (idle bus level).
// Assumes STAGES >= 2.
module tsi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tsi_bus_events.sv
// Derives SCL edges and start/stop conditions from synchronized lines.
// Assumes SDA moves only while SCL is low, except for start and stop.
module tsi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tsi_regbank.sv
// Register bank: configuration, three threshold words, alarm and critical
// flags. Temperature comes straight from the converter input. Assumes
// writes arrive as whole registers from the link layer.
module tsi_regbank
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] temp_in,
    input  logic              alarm_evt,
    input  logic              crit_evt,
    input  logic              rd_clear,
    output logic [BYTE_W-1:0] cfg_out,
    output logic [WORD_W-1:0] lim_low,
    output logic [WORD_W-1:0] lim_high,
    output logic [WORD_W-1:0] lim_crit,
    output logic              alarm_out,
    output logic              crit_out
);
    logic sd_entry;

    assign sd_entry = wr_en && (wr_sel == SEL_CFG) && wr_data[CFG_SHDN] && !cfg_out[CFG_SHDN];

    // Store host writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_out  <= '0;
            lim_low  <= '0;
            lim_high <= '0;
            lim_crit <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CFG:  cfg_out  <= wr_data[BYTE_W-1:0];
                SEL_LOW:  lim_low  <= wr_data;
                SEL_HIGH: lim_high <= wr_data;
                SEL_CRIT: lim_crit <= wr_data;
                default:  ;
            endcase
        end
    end

    // Keep alarm and critical flags; clears win over same-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_out <= 1'b0;
            crit_out  <= 1'b0;
        end else begin
            if (sd_entry || (rd_clear && cfg_out[CFG_INTM])) alarm_out <= 1'b0;
            else if (alarm_evt)                              alarm_out <= 1'b1;
            if (sd_entry)      crit_out <= 1'b0;
            else if (crit_evt) crit_out <= 1'b1;
        end
    end

    // Present the selected register to the link layer.
    always_comb begin
        case (rd_sel)
            SEL_TEMP: rd_data = temp_in;
            SEL_CFG:  rd_data = {{BYTE_W{1'b0}}, cfg_out};
            SEL_LOW:  rd_data = lim_low;
            SEL_HIGH: rd_data = lim_high;
            SEL_CRIT: rd_data = lim_crit;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tsi_link.sv
// Byte-level target protocol engine: address match, pointer latch, write
// assembly and read shifting. Assumes SCL/SDA are already synchronized and
// that events come from tsi_bus_events. SDA changes only after an SCL fall.
module tsi_link
    import tsi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_sel,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_clear
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    link_st_t          st;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] stage;
    logic [BYTE_W-1:0] tx;
    logic [1:0]        wcnt;
    logic              first_q;
    logic              nack;
    logic              next_first;
    logic [BYTE_W-1:0] byte_first;
    logic [BYTE_W-1:0] byte_next;

    // Choose the byte of the selected register to put on the bus.
    function automatic logic [BYTE_W-1:0] pick(input logic [PTR_W-1:0] s, input logic first,
                                               input logic [WORD_W-1:0] w);
        return (sel_wide(s) && first) ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

    assign next_first = sel_wide(ptr) ? !first_q : 1'b1;
    assign byte_first = pick(ptr, 1'b1, rd_data);
    assign byte_next  = pick(ptr, next_first, rd_data);

    // Protocol state machine; start and stop override any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= L_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            stage    <= '0;
            tx       <= '0;
            wcnt     <= '0;
            first_q  <= 1'b1;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= SEL_TEMP;
            wr_en    <= 1'b0;
            wr_sel   <= SEL_TEMP;
            wr_data  <= '0;
            rd_clear <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            rd_clear <= 1'b0;
            if (start_evt) begin
                st     <= L_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                st     <= L_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    L_ADDR, L_PTR, L_WDAT: begin
                        if (scl_rise && bitcnt != BITS) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == BITS) begin
                            bitcnt <= '0;
                            if (st == L_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe   <= 1'b1;
                                    nack     <= shreg[0];
                                    rd_clear <= shreg[0];
                                    st       <= L_ADDR_ACK;
                                end else begin
                                    st <= L_IDLE;
                                end
                            end else if (st == L_PTR) begin
                                ptr    <= shreg[PTR_W-1:0];
                                wcnt   <= '0;
                                sda_oe <= 1'b1;
                                st     <= L_PTR_ACK;
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= L_WDAT_ACK;
                                wr_sel <= ptr;
                                if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
                                if (ptr == SEL_CFG) begin
                                    if (wcnt == 2'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_data <= {{BYTE_W{1'b0}}, shreg};
                                    end
                                end else if (ptr != SEL_TEMP && sel_wide(ptr)) begin
                                    if (wcnt == 2'd0) stage <= shreg;
                                    else if (wcnt == 2'd1) begin
                                        wr_en   <= 1'b1;
                                        wr_data <= {stage, shreg};
                                    end
                                end
                            end
                        end
                    end
                    L_ADDR_ACK: if (scl_fall) begin
                        if (nack) begin
                            first_q <= 1'b1;
                            tx      <= byte_first;
                            sda_oe  <= !byte_first[BYTE_W-1];
                            bitcnt  <= 4'd1;
                            st      <= L_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= L_PTR;
                        end
                    end
                    L_PTR_ACK, L_WDAT_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= L_WDAT;
                    end
                    L_RDAT: if (scl_fall) begin
                        if (bitcnt != BITS) begin
                            sda_oe <= !tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= L_RACK;
                        end
                    end
                    L_RACK: begin
                        if (scl_rise) nack <= sda_s;
                        else if (scl_fall) begin
                            if (nack) st <= L_IDLE;
                            else begin
                                first_q <= next_first;
                                tx      <= byte_next;
                                sda_oe  <= !byte_next[BYTE_W-1];
                                bitcnt  <= 4'd1;
                                st      <= L_RDAT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/thermo_i2c_target.sv
// Top of the thermal register target: line synchronizers, bus event
// detection, protocol engine and register bank. Assumes clk runs at least
// about 16 times faster than SCL.
module thermo_i2c_target
    import tsi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [WORD_W-1:0] temp_in,
    input  logic              alarm_evt,
    input  logic              crit_evt,
    output logic              alarm_out,
    output logic              crit_out,
    output logic [BYTE_W-1:0] cfg_out,
    output logic [WORD_W-1:0] lim_low,
    output logic [WORD_W-1:0] lim_high,
    output logic [WORD_W-1:0] lim_crit
);
    logic [1:0]        raw_lines;
    logic [1:0]        sync_lines;
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_sel;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_data;
    logic              rd_clear;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        tsi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_lines[g]), .q(sync_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    tsi_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    tsi_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
        .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_clear(rd_clear)
    );

    tsi_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(ptr), .rd_data(rd_data), .temp_in(temp_in),
        .alarm_evt(alarm_evt), .crit_evt(crit_evt), .rd_clear(rd_clear),
        .cfg_out(cfg_out), .lim_low(lim_low), .lim_high(lim_high),
        .lim_crit(lim_crit), .alarm_out(alarm_out), .crit_out(crit_out)
    );
endmodule

// File: rtl/thermo_i2c_chk.sv
// Property checker for thermo_i2c_target, attached by bind. Observes the
// pointer, write strobes, read-clear pulse, stop events and outputs.
module thermo_i2c_chk
    import tsi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [PTR_W-1:0]  wr_sel,
    input logic              rd_clear,
    input logic [PTR_W-1:0]  ptr,
    input logic [BYTE_W-1:0] cfg_out,
    input logic              alarm_out,
    input logic              crit_out
);
    // R1
    ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ptr == SEL_TEMP);

    // R4
    temp_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_sel != SEL_TEMP);

    // R5
    drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R8
    intm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && cfg_out[CFG_INTM]) |=> !alarm_out);

    // R9
    shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_out[CFG_SHDN]) |-> (!alarm_out && !crit_out));
endmodule

bind thermo_i2c_target thermo_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .rd_clear(rd_clear),
    .ptr(ptr), .cfg_out(cfg_out), .alarm_out(alarm_out), .crit_out(crit_out)
);

// File: tb/sim_thermo_i2c_target.sv
module sim_thermo_i2c_target;
    localparam logic [6:0] DEV = 7'h48;
    localparam int H = 16;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [15:0] temp_in = 16'h1A53;
    logic alarm_evt = 1'b0;
    logic crit_evt = 1'b0;
    logic alarm_out, crit_out;
    logic [7:0] cfg_out;
    logic [15:0] lim_low, lim_high, lim_crit;

    int n_vec = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [2:0]  m_ptr = 3'd0;
    logic [7:0]  m_cfg = 8'h00;
    logic [15:0] m_low = 16'h0, m_high = 16'h0, m_crit = 16'h0;
    logic        m_alarm = 1'b0, m_crito = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    thermo_i2c_target #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .temp_in(temp_in), .alarm_evt(alarm_evt), .crit_evt(crit_evt),
        .alarm_out(alarm_out), .crit_out(crit_out), .cfg_out(cfg_out),
        .lim_low(lim_low), .lim_high(lim_high), .lim_crit(lim_crit)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mreg(input logic [2:0] p);
        case (p)
            3'd0: return temp_in;
            3'd1: return {8'h00, m_cfg};
            3'd2: return m_low;
            3'd3: return m_high;
            3'd4: return m_crit;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [7:0] expb(input int k);
        logic [15:0] r = mreg(m_ptr);
        logic wide = (m_ptr == 3'd0) || (m_ptr >= 3'd2 && m_ptr <= 3'd4);
        if (wide && (k % 2 == 0)) return r[15:8];
        return r[7:0];
    endfunction

    // Per-clock comparison of register outputs and bus release while idle.
    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            chk("R3", "cfg_out", {24'h0, cfg_out}, {24'h0, m_cfg});
            chk("R3", "lim_low", {16'h0, lim_low}, {16'h0, m_low});
            chk("R3", "lim_high", {16'h0, lim_high}, {16'h0, m_high});
            chk("R3", "lim_crit", {16'h0, lim_crit}, {16'h0, m_crit});
            chk("R11", "alarm_out", {31'h0, alarm_out}, {31'h0, m_alarm});
            chk("R11", "crit_out", {31'h0, crit_out}, {31'h0, m_crito});
            chk("R7", "sda_oe idle", {31'h0, sda_oe}, 32'h0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ackd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(H);
            scl_m = 1'b1; wait_cyc(H);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H / 2);
        ackd = !sda_bus; wait_cyc(H / 2);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(H);
            scl_m = 1'b1; wait_cyc(H / 2);
            b[i] = sda_bus; wait_cyc(H / 2);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = !ack; wait_cyc(H);
        scl_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(Q);
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic [2:0] p, input int n, input logic [15:0] d, input string req);
        bit a;
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk(req, "addr ack", {31'h0, a}, 32'h1);
        send_byte({5'h0, p}, a);   chk(req, "ptr ack", {31'h0, a}, 32'h1);
        if (n == 1) begin
            send_byte(d[7:0], a); chk(req, "data ack", {31'h0, a}, 32'h1);
        end else if (n == 2) begin
            send_byte(d[15:8], a); chk(req, "data hi ack", {31'h0, a}, 32'h1);
            send_byte(d[7:0], a);  chk(req, "data lo ack", {31'h0, a}, 32'h1);
        end
        bus_stop(); wait_cyc(4);
        m_ptr = p;
        if (p == 3'd1 && n >= 1) begin
            if (d[0] && !m_cfg[0]) begin m_alarm = 1'b0; m_crito = 1'b0; end
            m_cfg = d[7:0];
        end else if (n == 2) begin
            if (p == 3'd2) m_low = d;
            if (p == 3'd3) m_high = d;
            if (p == 3'd4) m_crit = d;
        end
        cmp_en = 1'b1;
    endtask

    task automatic rd_bytes(input bit set_ptr, input logic [2:0] p, input int n,
                            input bit last_ack, input string req);
        bit a;
        logic [7:0] b;
        cmp_en = 1'b0;
        bus_start();
        if (set_ptr) begin
            send_byte({DEV, 1'b0}, a); chk(req, "addr w ack", {31'h0, a}, 32'h1);
            send_byte({5'h0, p}, a);   chk(req, "ptr ack", {31'h0, a}, 32'h1);
            m_ptr = p;
            bus_start();
        end
        send_byte({DEV, 1'b1}, a); chk(req, "addr r ack", {31'h0, a}, 32'h1);
        if (m_cfg[1]) m_alarm = 1'b0;
        for (int k = 0; k < n; k++) begin
            recv_byte((k == n - 1) ? last_ack : 1'b1, b);
            chk(req, $sformatf("read byte %0d", k), {24'h0, b}, {24'h0, expb(k)});
        end
        bus_stop(); wait_cyc(4);
        chk("R6", "bus high after stop", {31'h0, sda_bus}, 32'h1);
        cmp_en = 1'b1;
    endtask

    task automatic pulse(input bit a, input bit c);
        cmp_en = 1'b0;
        alarm_evt = a; crit_evt = c; wait_cyc(1);
        alarm_evt = 1'b0; crit_evt = 1'b0;
        if (a) m_alarm = 1'b1;
        if (c) m_crito = 1'b1;
        wait_cyc(2);
        cmp_en = 1'b1;
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(4);
        // R1 reset state
        chk("R1", "sda_oe after reset", {31'h0, sda_oe}, 32'h0);
        chk("R1", "cfg after reset", {24'h0, cfg_out}, 32'h0);
        chk("R1", "alarm after reset", {31'h0, alarm_out}, 32'h0);
        cmp_en = 1'b1;

        // R1 R5: read with no pointer byte gives temperature, high byte first
        rd_bytes(1'b0, 3'd0, 2, 1'b0, "R1");

        // R3: configuration one byte, interrupt mode
        wr_reg(3'd1, 1, 16'h0002, "R3");
        // R3 R5: limits two bytes, read back after repeated start
        wr_reg(3'd3, 2, 16'h5A34, "R3");
        rd_bytes(1'b1, 3'd3, 2, 1'b0, "R5");
        // R2: pointer persists
        rd_bytes(1'b0, 3'd3, 2, 1'b0, "R2");
        wr_reg(3'd2, 2, 16'h8071, "R3");
        wr_reg(3'd4, 2, 16'hC3A5, "R3");
        // R5: extra ACKed bytes restart from high byte
        rd_bytes(1'b0, 3'd4, 3, 1'b0, "R5");
        rd_bytes(1'b1, 3'd1, 2, 1'b0, "R5");

        // R4: write to temperature acked and ignored
        wr_reg(3'd0, 2, 16'hFFFF, "R4");
        rd_bytes(1'b0, 3'd0, 2, 1'b0, "R4");

        // R7: foreign address not acknowledged, bus never driven
        bus_start();
        send_byte({7'h11, 1'b0}, a);
        chk("R7", "foreign addr nack", {31'h0, a}, 32'h0);
        send_byte(8'h00, a);
        chk("R7", "no ack after foreign addr", {31'h0, a}, 32'h0);
        bus_stop(); wait_cyc(4);

        // R11 R8: events set outputs; read clears alarm in interrupt mode
        pulse(1'b1, 1'b1);
        chk("R11", "alarm set", {31'h0, alarm_out}, 32'h1);
        rd_bytes(1'b0, 3'd1, 1, 1'b0, "R8");
        chk("R8", "alarm cleared by read", {31'h0, alarm_out}, 32'h0);
        chk("R8", "crit kept by read", {31'h0, crit_out}, 32'h1);
        wr_reg(3'd1, 1, 16'h0000, "R8");
        pulse(1'b1, 1'b0);
        rd_bytes(1'b0, 3'd1, 1, 1'b0, "R8");
        chk("R8", "alarm kept in comparator mode", {31'h0, alarm_out}, 32'h1);

        // R9: shutdown entry clears both outputs
        wr_reg(3'd1, 1, 16'h0001, "R9");
        chk("R9", "alarm after shutdown", {31'h0, alarm_out}, 32'h0);
        chk("R9", "crit after shutdown", {31'h0, crit_out}, 32'h0);
        wr_reg(3'd1, 1, 16'h0000, "R9");

        // R6: ACK on last byte accepted (next bit released) then stop
        temp_in = 16'h9A53;
        rd_bytes(1'b1, 3'd0, 2, 1'b1, "R6");
        rd_bytes(1'b0, 3'd0, 2, 1'b0, "R6");

        // R10: truncated read holds SDA low, nine clocks release it
        cmp_en = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h03, a);
        m_ptr = 3'd3;
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, b);
        chk("R10", "first byte", {24'h0, b}, 32'h5A);
        wait_cyc(H);
        chk("R10", "sda stuck low", {31'h0, sda_bus}, 32'h0);
        sda_m = 1'b1;
        for (int i = 0; i < 9; i++) begin
            wait_cyc(H); scl_m = 1'b1;
            wait_cyc(H); scl_m = 1'b0;
            wait_cyc(Q);
        end
        wait_cyc(H);
        chk("R10", "sda released after nine clocks", {31'h0, sda_bus}, 32'h1);
        bus_stop(); wait_cyc(4);
        cmp_en = 1'b1;
        rd_bytes(1'b0, 3'd3, 2, 1'b0, "R10");

        wait_cyc(8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule